// File: doc/BRIEF.md
# Distributed-Arithmetic Tenth-Order IIR Filter

This block filters a stream of signed samples through a fixed tenth-order recursive filter. Each output is built from two dot products. A feedforward product uses eleven numerator taps over the newest input and the ten inputs before it. A feedback product uses ten denominator taps over the ten most recent outputs. Neither product uses a multiplier. The delayed samples are walked one bit position per clock, least significant bit first. At each bit, every group of up to four taps addresses a 16-entry table of precomputed coefficient partial sums. The group results are added, weighted by the bit position, and accumulated. On the sign-bit cycle the weighted value is subtracted instead of added.

The two coefficient sets are stored at different fixed-point scales, so the feedback sum is shifted up to the numerator scale before the two sums are combined. The combined value is then rounded and saturated. A source offers a sample with `in_valid` and the block takes it only while `in_ready` is high. One serial pass later, `out_valid` pulses with the result. The coefficient tables are constants built into the block.

Top module: `iir_da_filter`

## Requirements
- R1: After a synchronous reset, `out_valid` is low, `in_ready` is high, and every stored input and output sample is zero, so a stream of zero inputs gives zero outputs.
- R2: A sample is taken only at a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low from the next cycle until the result appears. `in_valid` while `in_ready` is low has no effect on any later output.
- R3: `out_valid` is high for exactly one cycle, DATA_W+1 clock edges after the accepting edge. `in_ready` is high again in that same cycle.
- R4: With x[n-k] the inputs and y[n-k] the earlier outputs, the block computes s = sum over k=0..10 of b_k*x[n-k] − 2^9 * sum over k=1..10 of a_k*y[n-k]. The numerator integers (real value times 2^14) are b0..b10 = 12000, 9000, 5000, 2000, −1000, −1500, 800, 400, −200, 100, −50. The denominator integers (real value times 2^5) are a1..a10 = −16, 4, 0, 0, −2, 0, 0, 0, 0, 1. The first output after reset for an input of 16384 is 12000.
- R5: The output is floor((s + 2^13) / 2^14), so exact halves round toward positive infinity. As the first sample after reset, 256 gives 188 and −256 gives −187.
- R6: The rounded value is saturated to the range −2^(DATA_W−1) to 2^(DATA_W−1)−1. A long run of 32767 settles at 32767, and the saturated value is what enters the output history.
- R7: Inputs across the full two's-complement range, including −2^(DATA_W−1), are handled exactly. A long run of −32768 settles at −32768.
- R8: After a single nonzero input followed by zeros, outputs later than the eleventh come only from the feedback path. They follow R4 and are not all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample offered |
| in_data | input | DATA_W | Signed input sample |
| in_ready | output | 1 | Block is idle and will take a sample |
| out_valid | output | 1 | One-cycle strobe marking a new output |
| out_data | output | DATA_W | Signed filtered output sample |

## Verification
The bench holds `in_valid` high through whole serial passes with changing data. A design that latched a sample while busy would shift its history and corrupt every later output against the reference model. Directed samples of ±256 land on exact rounding halves, where truncation or symmetric rounding gives 187 or −188. Long full-scale runs of both polarities expose a missing clamp, which shows up as wraparound and an oscillating output. They also expose a sign-bit cycle that adds instead of subtracts, which shows up when the input is at its most negative value. An impulse followed by zeros checks that the tail beyond the eleventh output is driven by the feedback history with the scale realignment applied. Getting the realignment wrong gives a tail of the wrong size.

// File: rtl/iir_da_pkg.sv
`timescale 1ns/1ps
package iir_da_pkg;

    localparam int NUM_TAPS    = 11;
    localparam int DEN_TAPS    = 10;
    localparam int GRP_TAPS    = 4;
    localparam int LUT_DEPTH   = 1 << GRP_TAPS;
    localparam int NUM_FRAC    = 14;
    localparam int DEN_FRAC    = 5;
    localparam int ALIGN_SHIFT = NUM_FRAC - DEN_FRAC;
    localparam int LUT_W       = 24;

    typedef enum logic [1:0] {
        PASS_IDLE   = 2'd0,
        PASS_BUSY   = 2'd1,
        PASS_FINISH = 2'd2
    } pass_state_e;

    // numerator integers, scale 2^14, index k applies to x[n-k]
    function automatic int num_coef(input int k);
        case (k)
            0:  return 12000;
            1:  return 9000;
            2:  return 5000;
            3:  return 2000;
            4:  return -1000;
            5:  return -1500;
            6:  return 800;
            7:  return 400;
            8:  return -200;
            9:  return 100;
            10: return -50;
            default: return 0;
        endcase
    endfunction

    // denominator integers, scale 2^5, index k applies to y[n-1-k]
    function automatic int den_coef(input int k);
        case (k)
            0: return -16;
            1: return 4;
            4: return -2;
            9: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic int tap_coef(input bit feedback, input int k);
        return feedback ? den_coef(k) : num_coef(k);
    endfunction

    // sum of the group coefficients selected by the set bits of pattern
    function automatic int group_psum(input bit feedback, input int base,
                                      input int count, input int pattern);
        int acc;
        acc = 0;
        for (int i = 0; i < GRP_TAPS; i++) begin
            if (i < count && ((pattern >> i) & 1) == 1)
                acc += tap_coef(feedback, base + i);
        end
        return acc;
    endfunction

endpackage

// File: rtl/da_group_lut.sv
`timescale 1ns/1ps
module da_group_lut
    import iir_da_pkg::*;
#(
    parameter bit FEEDBACK = 1'b0,
    parameter int BASE     = 0,
    parameter int COUNT    = 4
) (
    input  logic [GRP_TAPS-1:0]     addr,
    output logic signed [LUT_W-1:0] psum
);

    logic signed [LUT_W-1:0] entry [LUT_DEPTH];

    for (genvar e = 0; e < LUT_DEPTH; e++) begin : g_entry
        assign entry[e] = LUT_W'(group_psum(FEEDBACK, BASE, COUNT, e));
    end

    assign psum = entry[addr];

endmodule

// File: rtl/da_serial_acc.sv
`timescale 1ns/1ps
module da_serial_acc
    import iir_da_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int TAPS     = 11,
    parameter bit FEEDBACK = 1'b0,
    parameter int ACC_W    = 40
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           clear,
    input  logic                           step,
    input  logic                           sign_cyc,
    input  logic [$clog2(DATA_W)-1:0]      bit_idx,
    input  logic [TAPS-1:0][DATA_W-1:0]    taps_in,
    output logic signed [ACC_W-1:0]        acc
);

    localparam int NGRP  = (TAPS + GRP_TAPS - 1) / GRP_TAPS;
    localparam int SUM_W = LUT_W + $clog2(NGRP) + 1;

    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
    } acc_state_t;

    acc_state_t st_d, st_q;

    logic signed [LUT_W-1:0] grp_out [NGRP];
    logic signed [SUM_W-1:0] bit_sum;
    logic signed [ACC_W-1:0] weighted;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int BASE = g * GRP_TAPS;
        localparam int CNT  = (TAPS - BASE) < GRP_TAPS ? (TAPS - BASE) : GRP_TAPS;
        logic [GRP_TAPS-1:0] addr;
        for (genvar i = 0; i < GRP_TAPS; i++) begin : g_bit
            if (i < CNT) begin : g_used
                assign addr[i] = taps_in[BASE + i][bit_idx];
            end else begin : g_pad
                assign addr[i] = 1'b0;
            end
        end
        da_group_lut #(
            .FEEDBACK (FEEDBACK),
            .BASE     (BASE),
            .COUNT    (CNT)
        ) u_lut (
            .addr (addr),
            .psum (grp_out[g])
        );
    end

    always_comb begin
        bit_sum = '0;
        for (int g = 0; g < NGRP; g++)
            bit_sum = bit_sum + SUM_W'(grp_out[g]);
        weighted = ACC_W'(bit_sum) <<< bit_idx;
        st_d = st_q;
        if (clear)
            st_d.acc = '0;
        else if (step)
            st_d.acc = sign_cyc ? (st_q.acc - weighted) : (st_q.acc + weighted);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign acc = st_q.acc;

    // a fresh pass always starts from an empty accumulator
    assert_clear_zero_R1: assert property (@(posedge clk) disable iff (rst)
        clear |=> (acc == '0));

    // outside a pass the partial sum must not drift
    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (!clear && !step) |=> $stable(acc));

endmodule

// File: rtl/iir_round_sat.sv
`timescale 1ns/1ps
module iir_round_sat #(
    parameter int IN_W  = 50,
    parameter int FRAC  = 14,
    parameter int OUT_W = 16
) (
    input  logic signed [IN_W-1:0]  value,
    output logic signed [OUT_W-1:0] result
);

    localparam logic signed [IN_W:0] HALF =
        {{(IN_W - FRAC + 1){1'b0}}, 1'b1, {(FRAC - 1){1'b0}}};
    localparam logic signed [IN_W:0] MAXV =
        {{(IN_W - OUT_W + 2){1'b0}}, {(OUT_W - 1){1'b1}}};
    localparam logic signed [IN_W:0] MINV =
        {{(IN_W - OUT_W + 2){1'b1}}, {(OUT_W - 1){1'b0}}};

    logic signed [IN_W:0] biased;
    logic signed [IN_W:0] shifted;

    always_comb begin
        biased  = {value[IN_W-1], value} + HALF;
        shifted = biased >>> FRAC;
        if (shifted > MAXV)
            result = {1'b0, {(OUT_W - 1){1'b1}}};
        else if (shifted < MINV)
            result = {1'b1, {(OUT_W - 1){1'b0}}};
        else
            result = shifted[OUT_W-1:0];
    end

endmodule

// File: rtl/iir_da_filter.sv
`timescale 1ns/1ps
module iir_da_filter
    import iir_da_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    localparam int BIT_W = $clog2(DATA_W);
    localparam int SUM_W = ACC_W + ALIGN_SHIFT + 1;

    typedef struct packed {
        pass_state_e                        st;
        logic [BIT_W-1:0]                   bitc;
        logic [NUM_TAPS-1:0][DATA_W-1:0]    xh;
        logic [DEN_TAPS-1:0][DATA_W-1:0]    yh;
        logic                               out_valid;
        logic [DATA_W-1:0]                  out_data;
    } filt_state_t;

    filt_state_t r_d, r_q;

    logic                     accept;
    logic                     step;
    logic                     sign_cyc;
    logic signed [ACC_W-1:0]  ff_acc;
    logic signed [ACC_W-1:0]  fb_acc;
    logic signed [SUM_W-1:0]  combined;
    logic signed [DATA_W-1:0] y_sat;

    assign in_ready = (r_q.st == PASS_IDLE);
    assign accept   = in_valid && in_ready;
    assign step     = (r_q.st == PASS_BUSY);
    assign sign_cyc = (r_q.bitc == BIT_W'(DATA_W - 1));

    da_serial_acc #(
        .DATA_W   (DATA_W),
        .TAPS     (NUM_TAPS),
        .FEEDBACK (1'b0),
        .ACC_W    (ACC_W)
    ) u_ff (
        .clk      (clk),
        .rst      (rst),
        .clear    (accept),
        .step     (step),
        .sign_cyc (sign_cyc),
        .bit_idx  (r_q.bitc),
        .taps_in  (r_q.xh),
        .acc      (ff_acc)
    );

    da_serial_acc #(
        .DATA_W   (DATA_W),
        .TAPS     (DEN_TAPS),
        .FEEDBACK (1'b1),
        .ACC_W    (ACC_W)
    ) u_fb (
        .clk      (clk),
        .rst      (rst),
        .clear    (accept),
        .step     (step),
        .sign_cyc (sign_cyc),
        .bit_idx  (r_q.bitc),
        .taps_in  (r_q.yh),
        .acc      (fb_acc)
    );

    // bring the feedback sum onto the numerator scale before subtracting
    assign combined = SUM_W'(ff_acc) - (SUM_W'(fb_acc) <<< ALIGN_SHIFT);

    iir_round_sat #(
        .IN_W  (SUM_W),
        .FRAC  (NUM_FRAC),
        .OUT_W (DATA_W)
    ) u_round (
        .value  (combined),
        .result (y_sat)
    );

    always_comb begin
        r_d = r_q;
        r_d.out_valid = 1'b0;
        unique case (r_q.st)
            PASS_IDLE: begin
                if (accept) begin
                    for (int k = NUM_TAPS - 1; k > 0; k--)
                        r_d.xh[k] = r_q.xh[k-1];
                    r_d.xh[0] = in_data;
                    r_d.bitc  = '0;
                    r_d.st    = PASS_BUSY;
                end
            end
            PASS_BUSY: begin
                r_d.bitc = r_q.bitc + BIT_W'(1);
                if (sign_cyc) begin
                    r_d.bitc = '0;
                    r_d.st   = PASS_FINISH;
                end
            end
            PASS_FINISH: begin
                for (int k = DEN_TAPS - 1; k > 0; k--)
                    r_d.yh[k] = r_q.yh[k-1];
                r_d.yh[0]     = y_sat;
                r_d.out_data  = y_sat;
                r_d.out_valid = 1'b1;
                r_d.st        = PASS_IDLE;
            end
            default: r_d.st = PASS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign out_valid = r_q.out_valid;
    assign out_data  = r_q.out_data;

    // the result strobe never stretches over two cycles
    assert_pulse_one_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // the result appears together with the return to idle
    assert_valid_idle_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> in_ready);

    // taking a sample closes the input until the pass is over
    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    // input history is frozen while bits are being walked
    assert_hist_stable_R4: assert property (@(posedge clk) disable iff (rst)
        step |=> $stable(r_q.xh));

endmodule

// File: tb/iir_da_filter_bench.sv
`timescale 1ns/1ps
module iir_da_filter_bench;

    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              in_ready;
    logic              out_valid;
    logic [DATA_W-1:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    bit chk_en = 1'b0;

    always #2.5 clk = ~clk;

    iir_da_filter #(.DATA_W(DATA_W)) u_iir_da_filter (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // reference coefficients taken from R4
    int bk [11] = '{12000, 9000, 5000, 2000, -1000, -1500, 800, 400, -200, 100, -50};
    int ak [10] = '{-16, 4, 0, 0, -2, 0, 0, 0, 0, 1};

    longint xm [11];
    longint ym [10];
    int     m_cnt   = 0;
    bit     m_valid = 1'b0;
    longint m_data  = 0;
    longint m_pend  = 0;

    // behavioural cycle model
    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_valid = 1'b0; m_data = 0;
            foreach (xm[i]) xm[i] = 0;
            foreach (ym[i]) ym[i] = 0;
        end else begin
            m_valid = 1'b0;
            if (m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_valid = 1'b1;
                    m_data  = m_pend;
                end
            end else if (in_valid) begin
                longint s, y;
                for (int i = 10; i > 0; i--) xm[i] = xm[i-1];
                xm[0] = longint'($signed(in_data));
                s = 0;
                for (int i = 0; i < 11; i++) s += longint'(bk[i]) * xm[i];
                for (int i = 0; i < 10; i++) s -= 512 * longint'(ak[i]) * ym[i];
                y = (s + 8192) >>> 14;
                if (y > 32767) y = 32767;
                if (y < -32768) y = -32768;
                for (int i = 9; i > 0; i--) ym[i] = ym[i-1];
                ym[0]  = y;
                m_pend = y;
                m_cnt  = DATA_W + 1;
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (chk_en && !rst && !done) begin
            checks++;
            if (in_ready !== (m_cnt == 0)) begin
                errors++;
                $display("FAIL R2 in_ready actual %0b expected %0b", in_ready, (m_cnt == 0));
            end
            checks++;
            if (out_valid !== m_valid) begin
                errors++;
                $display("FAIL R3 out_valid actual %0b expected %0b", out_valid, m_valid);
            end
            if (m_valid) begin
                checks++;
                if (longint'($signed(out_data)) != m_data) begin
                    errors++;
                    $display("FAIL R4 out_data actual %0d expected %0d",
                             $signed(out_data), m_data);
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
        check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
    endtask

    task automatic send(input int v, output int y);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = DATA_W'(v);
        @(negedge clk);
        in_valid = 1'b0;
        while (!out_valid) @(negedge clk);
        y = int'($signed(out_data));
    endtask

    initial begin
        int y;
        bit tail_nz;
        repeat (3) @(negedge clk);
        chk_en = 1'b1;
        do_reset();

        // R1: zero stream stays zero
        for (int i = 0; i < 12; i++) begin
            send(0, y);
            check(y == 0, "R1 zero stream", y, 0);
        end

        // R5: exact halves
        do_reset();
        send(256, y);
        check(y == 188, "R5 positive half", y, 188);
        do_reset();
        send(-256, y);
        check(y == -187, "R5 negative half", y, -187);

        // R4 and R8: impulse and its feedback tail
        do_reset();
        send(16384, y);
        check(y == 12000, "R4 impulse head", y, 12000);
        tail_nz = 1'b0;
        for (int i = 1; i <= 24; i++) begin
            send(0, y);
            if (i >= 11 && y != 0) tail_nz = 1'b1;
        end
        check(tail_nz, "R8 feedback tail nonzero", tail_nz, 1);

        // R6: positive saturation
        do_reset();
        for (int i = 0; i < 40; i++) send(32767, y);
        check(y == 32767, "R6 positive clamp", y, 32767);

        // R7: most negative input and negative clamp
        do_reset();
        for (int i = 0; i < 40; i++) send(-32768, y);
        check(y == -32768, "R7 negative clamp", y, -32768);

        // R7: full-scale alternation, compared cycle by cycle
        for (int i = 0; i < 16; i++) send((i % 2) ? 32767 : -32768, y);

        // R2: valid held high through passes with changing data
        do_reset();
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = DATA_W'($urandom_range(4000)) - DATA_W'(2000);
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (DATA_W + 4) @(negedge clk);

        // random samples with gaps, small and full-scale
        do_reset();
        for (int i = 0; i < 200; i++) begin
            int v;
            v = (i < 100) ? (int'($urandom_range(6000)) - 3000)
                          : (int'($urandom_range(65535)) - 32768);
            repeat ($urandom_range(3)) @(negedge clk);
            send(v, y);
        end
        repeat (5) @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule